// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller with Special Mask Mode

This block gathers up to eight interrupt request lines. It holds three per-line registers: pending requests, levels in service and mask bits. It drives an interrupt output whenever the best eligible pending request may be signalled. A pulse on the acknowledge input moves the winning level from pending to in service, and the level's index appears on the vector output. Software programs the block through a single register write port. A two-bit command kind on that port selects one of four writes: an initialization word, a mask load, a non-specific end-of-interrupt (EOI), or a mode/control word.

Priority rotates around a lowest-priority pointer. Scans start one place above the pointer and wrap. Two modes alter arbitration. Special mask mode lets the mask alone decide which levels may interrupt, and it makes an EOI pass over in-service levels that are masked. Special fully nested mode keeps line 2 in service from blocking any request.

Top module: `prio_intc`

## Requirements
- R1: Reset, and an initialization write (kind 0), clear the pending, in-service and mask registers. They set the lowest-priority pointer to 7, clear special mask mode and point readback at the pending register. Initialization data bit 4 loads special fully nested mode, and reset clears it.
- R2: Scans take lines in the order pointer+1, pointer+2 and so on, modulo 8. After initialization, line 0 ranks highest and line 7 lowest.
- R3: When an acknowledge pulse meets a raised interrupt output, the winning line's in-service bit is set and its pending bit is cleared. From the next cycle its index is shown on the vector output. An acknowledge with the output low changes no register and leaves the vector as it was.
- R4: Outside special mask mode, a pending unmasked line is signalled only when no in-service bit of equal or higher rank is set.
- R5: A line whose mask bit is 1 is never signalled. A mask write (kind 1) loads the mask from the data byte.
- R6: A control write (kind 3) with data bit 6 set loads special mask mode from data bit 5. With bit 6 clear, the mode is left unchanged.
- R7: While special mask mode is on, in-service bits do not block any request.
- R8: While special mask mode is on, an EOI (kind 2) passes over in-service bits whose mask bit is set. It clears the highest-ranked unmasked in-service bit instead.
- R9: With special fully nested mode on, the in-service bit of line 2 does not block arbitration.
- R10: An EOI that finds no eligible in-service bit changes no register.
- R11: An EOI with data bit 7 set also moves the lowest-priority pointer to the line it cleared.
- R12: A control write with data bit 1 set selects readback from data bit 0: 1 selects in-service and 0 selects pending. With bit 1 clear, the selection is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 8 | One-cycle pulses that set pending bits |
| ack_in | input | 1 | Acknowledge pulse |
| wr_en | input | 1 | Command write strobe |
| wr_kind | input | 2 | 0 init, 1 mask, 2 EOI, 3 control |
| wr_data | input | 8 | Command data byte |
| int_out | output | 1 | Interrupt request to the host |
| vec_out | output | 3 | Index of the last acknowledged line |
| rd_data | output | 8 | Pending or in-service register, as selected |

## Verification
The properties assume that a command write never arrives in the same cycle as an acknowledge. They also assume that a request pulse never targets the line being acknowledged in that cycle, because the outcome of that collision is not specified. The stimulus gives every write, request pulse and acknowledge a cycle of its own, so both assumptions hold at every edge. Expected vectors and register contents come from a hand walk of the rotation order, and each walk sets up the in-service and mask state that a given mode depends on.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    CMD_INIT = 2'd0,
    CMD_MASK = 2'd1,
    CMD_EOI  = 2'd2,
    CMD_CTL  = 2'd3
  } cmd_kind_e;

  localparam int INIT_SFNM_BIT = 4;
  localparam int EOI_ROT_BIT   = 7;
  localparam int CTL_SMM_EN    = 6;
  localparam int CTL_SMM_VAL   = 5;
  localparam int CTL_RD_EN     = 1;
  localparam int CTL_RD_ISR    = 0;
  localparam int SLAVE_LINE    = 2;
endpackage

// File: rtl/pic_pick.sv
module pic_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] lowp,
  output logic          found,
  output logic [IW-1:0] idx
);
  function automatic int rot_pos(input logic [IW-1:0] base, input int step);
    return (int'(base) + step) % N;
  endfunction

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N; k >= 1; k--) begin
      if (vec[rot_pos(lowp, k)]) begin
        found = 1'b1;
        idx   = IW'(rot_pos(lowp, k));
      end
    end
  end
endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  irr,
  input  logic [N-1:0]  isr,
  input  logic [N-1:0]  imr,
  input  logic          smm,
  input  logic          sfnm,
  input  logic [IW-1:0] lowp,
  output logic          win_vld,
  output logic [IW-1:0] win_idx
);
  import pic_pkg::*;

  logic [N-1:0] pend, blk, keep_mask;
  logic         first_found;

  always_comb begin
    keep_mask = '1;
    if (sfnm) keep_mask[SLAVE_LINE] = 1'b0;
  end

  assign pend = irr & ~imr;
  assign blk  = smm ? '0 : (isr & keep_mask);

  pic_pick #(.N(N), .IW(IW)) u_pick (
    .vec  (pend | blk),
    .lowp (lowp),
    .found(first_found),
    .idx  (win_idx)
  );

  assign win_vld = first_found && pend[win_idx] && !blk[win_idx];
endmodule

// File: rtl/pic_eoi.sv
module pic_eoi #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  isr,
  input  logic [N-1:0]  imr,
  input  logic          smm,
  input  logic [IW-1:0] lowp,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  clr
);
  logic [N-1:0] cand;

  assign cand = isr & ~(smm ? imr : '0);

  pic_pick #(.N(N), .IW(IW)) u_pick (
    .vec  (cand),
    .lowp (lowp),
    .found(hit),
    .idx  (idx)
  );

  assign clr = hit ? (N'(1) << idx) : '0;
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_in,
  input  logic          ack_in,
  input  logic          wr_en,
  input  logic [1:0]    wr_kind,
  input  logic [7:0]    wr_data,
  output logic          int_out,
  output logic [IW-1:0] vec_out,
  output logic [N-1:0]  rd_data
);
  import pic_pkg::*;

  logic [N-1:0]  irr_q, isr_q, imr_q;
  logic          smm_q, sfnm_q, rsel_q;
  logic [IW-1:0] lowp_q, vec_q;

  logic          win_vld;
  logic [IW-1:0] win_idx;
  logic          eoi_hit;
  logic [IW-1:0] eoi_idx;
  logic [N-1:0]  eoi_clr;

  logic          do_init, do_mask, do_eoi, do_ctl, ack_take, eoi_take;
  logic [N-1:0]  ack_set;

  pic_arb #(.N(N), .IW(IW)) u_arb (
    .irr(irr_q), .isr(isr_q), .imr(imr_q), .smm(smm_q), .sfnm(sfnm_q),
    .lowp(lowp_q), .win_vld(win_vld), .win_idx(win_idx)
  );

  pic_eoi #(.N(N), .IW(IW)) u_eoi (
    .isr(isr_q), .imr(imr_q), .smm(smm_q), .lowp(lowp_q),
    .hit(eoi_hit), .idx(eoi_idx), .clr(eoi_clr)
  );

  assign do_init  = wr_en && (wr_kind == CMD_INIT);
  assign do_mask  = wr_en && (wr_kind == CMD_MASK);
  assign do_eoi   = wr_en && (wr_kind == CMD_EOI);
  assign do_ctl   = wr_en && (wr_kind == CMD_CTL);
  assign ack_take = ack_in && win_vld;
  assign eoi_take = do_eoi && eoi_hit;
  assign ack_set  = ack_take ? (N'(1) << win_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || do_init) begin
      irr_q  <= '0;
      isr_q  <= '0;
      imr_q  <= '0;
      smm_q  <= 1'b0;
      rsel_q <= 1'b0;
      lowp_q <= IW'(N - 1);
      sfnm_q <= rst_n ? wr_data[INIT_SFNM_BIT] : 1'b0;
      if (!rst_n) vec_q <= '0;
    end else begin
      irr_q <= (irr_q & ~ack_set) | req_in;
      isr_q <= (isr_q | ack_set) & ~(eoi_take ? eoi_clr : '0);
      if (do_mask) imr_q <= wr_data[N-1:0];
      if (eoi_take && wr_data[EOI_ROT_BIT]) lowp_q <= eoi_idx;
      if (do_ctl && wr_data[CTL_SMM_EN]) smm_q <= wr_data[CTL_SMM_VAL];
      if (do_ctl && wr_data[CTL_RD_EN]) rsel_q <= wr_data[CTL_RD_ISR];
      if (ack_take) vec_q <= win_idx;
    end
  end

  assign int_out = win_vld;
  assign vec_out = vec_q;
  assign rd_data = rsel_q ? isr_q : irr_q;
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_in,
  input logic          wr_en,
  input logic [1:0]    wr_kind,
  input logic [7:0]    wr_data,
  input logic          int_out,
  input logic [IW-1:0] vec_out,
  input logic [N-1:0]  irr_q,
  input logic [N-1:0]  isr_q,
  input logic [N-1:0]  imr_q,
  input logic          smm_q,
  input logic [IW-1:0] lowp_q,
  input logic [IW-1:0] win_idx,
  input logic          eoi_hit,
  input logic [N-1:0]  eoi_clr
);
  // R5
  masked_never_signalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr_q[win_idx] && !imr_q[win_idx]));

  // R3
  ack_loads_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && int_out && !wr_en) |=> (vec_out == $past(win_idx)) && isr_q[$past(win_idx)]);

  // R1
  init_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == 2'd0) |=> (!smm_q && lowp_q == IW'(N - 1) && isr_q == '0));

  // R6
  smm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == 2'd3 && !wr_data[6]) |=> $stable(smm_q));

  // R8
  eoi_skips_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && smm_q) |-> ((eoi_clr & imr_q) == '0 && $onehot0(eoi_clr)));

  // R10
  eoi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == 2'd2 && !eoi_hit && !ack_in) |=> ($stable(isr_q) && $stable(lowp_q)));
endmodule

bind prio_intc pic_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_in(ack_in), .wr_en(wr_en), .wr_kind(wr_kind),
  .wr_data(wr_data), .int_out(int_out), .vec_out(vec_out), .irr_q(irr_q),
  .isr_q(isr_q), .imr_q(imr_q), .smm_q(smm_q), .lowp_q(lowp_q),
  .win_idx(win_idx), .eoi_hit(eoi_hit), .eoi_clr(eoi_clr)
);

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = '0;
  logic       ack_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_kind = '0;
  logic [7:0] wr_data = '0;
  logic       int_out;
  logic [2:0] vec_out;
  logic [7:0] rd_data;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  prio_intc u0 (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .ack_in(ack_in),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_data(wr_data),
    .int_out(int_out), .vec_out(vec_out), .rd_data(rd_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.sel)
        0:       act = {7'd0, int_out};
        1:       act = {5'd0, vec_out};
        default: act = rd_data;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual %0h expected %0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_item(input int sel, input logic [7:0] exp, input string tag);
    item_t it;
    it.sel = sel;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] kind, input logic [7:0] data);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_kind = kind; wr_data = data;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic raise(input logic [7:0] v);
    @(posedge clk); #1;
    req_in = v;
    @(posedge clk); #1;
    req_in = '0;
  endtask

  task automatic ack();
    @(posedge clk); #1;
    ack_in = 1'b1;
    @(posedge clk); #1;
    ack_in = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_item(0, 8'h00, "R1 reset int");
    expect_item(2, 8'h00, "R1 reset readback");

    wr(2'd0, 8'h00);
    raise(8'h28);
    expect_item(0, 8'h01, "R2 pending int");
    expect_item(2, 8'h28, "R12 pending readback");
    ack();
    expect_item(1, 8'h03, "R2 line3 before line5");
    expect_item(2, 8'h20, "R3 pending cleared");
    expect_item(0, 8'h00, "R4 lower blocked");
    wr(2'd3, 8'h03);
    expect_item(2, 8'h08, "R12 in-service readback");
    wr(2'd3, 8'h01);
    expect_item(2, 8'h08, "R12 select kept");
    wr(2'd3, 8'h02);

    raise(8'h02);
    expect_item(0, 8'h01, "R4 higher passes");
    ack();
    expect_item(1, 8'h01, "R3 vector 1");
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h03);
    expect_item(2, 8'h08, "R4 eoi clears highest");
    expect_item(0, 8'h00, "R4 still blocked");
    wr(2'd2, 8'h00);
    expect_item(0, 8'h01, "R4 unblocked");
    ack();
    expect_item(1, 8'h05, "R3 vector 5");
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h02);

    wr(2'd1, 8'h10);
    raise(8'h10);
    expect_item(0, 8'h00, "R5 masked");
    ack();
    expect_item(1, 8'h05, "R3 no-winner vector kept");
    expect_item(2, 8'h10, "R3 no-winner pending kept");
    wr(2'd1, 8'h00);
    expect_item(0, 8'h01, "R5 unmasked");
    ack();
    expect_item(1, 8'h04, "R3 vector 4");

    raise(8'h40);
    expect_item(0, 8'h00, "R4 line6 blocked by 4");
    wr(2'd3, 8'h63);
    expect_item(0, 8'h01, "R7 smm unblocks");
    expect_item(2, 8'h10, "R12 isr view");
    wr(2'd3, 8'h00);
    expect_item(0, 8'h01, "R6 mode kept");
    ack();
    expect_item(1, 8'h06, "R7 vector 6");
    expect_item(2, 8'h50, "R7 both in service");
    wr(2'd1, 8'h10);
    wr(2'd2, 8'h00);
    expect_item(2, 8'h10, "R8 masked skipped");
    wr(2'd2, 8'h00);
    expect_item(2, 8'h10, "R10 no eligible");
    wr(2'd3, 8'h40);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    expect_item(2, 8'h00, "R6 smm off eoi");

    wr(2'd0, 8'h10);
    raise(8'h04);
    ack();
    expect_item(1, 8'h02, "R9 vector 2");
    raise(8'h04);
    expect_item(0, 8'h01, "R9 line2 not blocking");
    ack();
    wr(2'd2, 8'h00);

    wr(2'd1, 8'hFF);
    raise(8'h08);
    wr(2'd3, 8'h60);
    wr(2'd0, 8'h00);
    expect_item(2, 8'h00, "R1 init clears pending");
    expect_item(0, 8'h00, "R1 init int low");
    raise(8'h81);
    expect_item(0, 8'h01, "R1 mask cleared");
    ack();
    expect_item(1, 8'h00, "R2 line0 first");
    wr(2'd2, 8'h80);
    ack();
    expect_item(1, 8'h07, "R11 rotated order");
    raise(8'h01);
    expect_item(0, 8'h00, "R11 line0 now lowest");
    wr(2'd2, 8'h80);
    expect_item(0, 8'h01, "R11 pointer back to 7");
    ack();
    expect_item(1, 8'h00, "R11 vector 0");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule